// File: doc/BRIEF.md
# Triplicated Voting Pipeline Register

This block sits between two stages of a processor pipeline and carries one parameterised payload word (data plus control bits) across the stage boundary. The word is held in three independent copies of flip-flops, all on one shared clock, and each copy feeds its own two-of-three majority voter. The three voted words leave on three separate output bundles, so each of the three logic copies of the next stage gets its own copy. If one stored copy or one voter is upset, the fault is masked and goes no further than this stage. The pipeline does not stall or pause for this.

Each lane has its own input. When the stage feeding this register is itself triplicated, each lane stores its own input copy. When it is not, a parameter switches each lane to store a majority of the three inputs, so that a lane fault is removed before storage. A shared enable stalls all three copies together. A synchronous reset clears all three copies in the same cycle. The register also reports which bit positions disagree across the copies and which copy dissents from the majority, so that faults can be counted.

Top module: `tmr_vote_reg`

## Requirements
- R1: While `rst_i` is high at a rising edge, all three copies clear to zero. After that edge every output word, `mism_o` and `err_o` read zero, whatever `en_i` is.
- R2: With `en_i` low and `rst_i` low at a rising edge, all three copies keep their values, so every output is unchanged after that edge.
- R3: With `en_i` high, a word presented identically on all three inputs appears on all three outputs after the next rising edge, and `err_o` and `mism_o` are then zero.
- R4: When one input lane differs from the other two in any set of bits (single fault), all three outputs carry the word of the two agreeing lanes. `err_o` bit k (lane a = bit 0, b = bit 1, c = bit 2) is set only for the dissenting lane.
- R5: `mism_o` bit i is high exactly when the three stored copies do not all hold the same value in bit i.
- R6: When two lanes are corrupted the same way in the same bits (double fault), the outputs carry the corrupted value in those bits. `mism_o` flags those bits, and `err_o` marks the one correct lane as the dissenter.
- R7: Masking adds no stall. The corrected word appears with the same one-cycle latency as a clean word, and the next clean word captured clears all flags.
- R8: With `UPSTREAM_TMR` = 0, each copy stores the bitwise majority of the three inputs. A single-lane fault therefore leaves `err_o` and `mism_o` at zero and the outputs correct.
- R9: The three output bundles always carry the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shared clock for all three copies |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Capture enable; low stalls all copies |
| din_a_i | input | W | Payload input, lane a |
| din_b_i | input | W | Payload input, lane b |
| din_c_i | input | W | Payload input, lane c |
| dout_a_o | output | W | Voted payload for next-stage copy a |
| dout_b_o | output | W | Voted payload for next-stage copy b |
| dout_c_o | output | W | Voted payload for next-stage copy c |
| mism_o | output | W | Per-bit disagreement among stored copies |
| err_o | output | 3 | Per-copy dissent flag (bit 0 = a, 1 = b, 2 = c) |

## Verification
A corrupted stored copy shows up one edge after capture. It does not change the voted words, but it appears as a set bit in `err_o` for that lane and in `mism_o` for the affected bits. A wrong word on the outputs therefore means that two copies went bad in the same bit, or that a voter is broken, and the flags show which. A broken hold or reset path shows one cycle after the edge concerned, as output words that differ from the values the bench expects.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;
  localparam int unsigned LANES = 3;
  typedef enum logic [1:0] {LANE_A = 2'd0, LANE_B = 2'd1, LANE_C = 2'd2} lane_e;
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] y_o
);
  function automatic logic [W-1:0] vote2of3(input logic [W-1:0] a,
                                            input logic [W-1:0] b,
                                            input logic [W-1:0] c);
    return (a & b) | (b & c) | (a & c);
  endfunction

  assign y_o = vote2of3(a_i, b_i, c_i);
endmodule

// File: rtl/tmr_lane_reg.sv
module tmr_lane_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)     q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/tmr_dissent.sv
module tmr_dissent #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] qa_i,
  input  logic [W-1:0] qb_i,
  input  logic [W-1:0] qc_i,
  output logic [W-1:0] mism_o,
  output logic [2:0]   err_o
);
  logic [W-1:0] ref_w;

  tmr_voter #(.W(W)) u_ref (.a_i(qa_i), .b_i(qb_i), .c_i(qc_i), .y_o(ref_w));

  function automatic logic [W-1:0] not_all_equal(input logic [W-1:0] a,
                                                 input logic [W-1:0] b,
                                                 input logic [W-1:0] c);
    return (a ^ b) | (b ^ c);
  endfunction

  assign mism_o   = not_all_equal(qa_i, qb_i, qc_i);
  assign err_o[0] = |(qa_i ^ ref_w);
  assign err_o[1] = |(qb_i ^ ref_w);
  assign err_o[2] = |(qc_i ^ ref_w);
endmodule

// File: rtl/tmr_vote_reg.sv
module tmr_vote_reg
  import tmr_vote_pkg::*;
#(
  parameter int unsigned W            = 32,
  parameter bit          UPSTREAM_TMR = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic [W-1:0] din_a_i,
  input  logic [W-1:0] din_b_i,
  input  logic [W-1:0] din_c_i,
  output logic [W-1:0] dout_a_o,
  output logic [W-1:0] dout_b_o,
  output logic [W-1:0] dout_c_o,
  output logic [W-1:0] mism_o,
  output logic [2:0]   err_o
);
  logic [W-1:0] din_l  [LANES];
  logic [W-1:0] d_l    [LANES];
  logic [W-1:0] q_l    [LANES];
  logic [W-1:0] vote_l [LANES];

  assign din_l[LANE_A] = din_a_i;
  assign din_l[LANE_B] = din_b_i;
  assign din_l[LANE_C] = din_c_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (UPSTREAM_TMR) begin : g_own
      assign d_l[k] = din_l[k];
    end else begin : g_pre
      tmr_voter #(.W(W)) u_in_vote (
        .a_i(din_l[0]), .b_i(din_l[1]), .c_i(din_l[2]), .y_o(d_l[k])
      );
    end

    tmr_lane_reg #(.W(W)) u_copy (
      .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .d_i(d_l[k]), .q_o(q_l[k])
    );

    tmr_voter #(.W(W)) u_out_vote (
      .a_i(q_l[0]), .b_i(q_l[1]), .c_i(q_l[2]), .y_o(vote_l[k])
    );
  end

  tmr_dissent #(.W(W)) u_dissent (
    .qa_i(q_l[0]), .qb_i(q_l[1]), .qc_i(q_l[2]), .mism_o(mism_o), .err_o(err_o)
  );

  assign dout_a_o = vote_l[LANE_A];
  assign dout_b_o = vote_l[LANE_B];
  assign dout_c_o = vote_l[LANE_C];
endmodule

// File: rtl/tmr_vote_reg_chk.sv
module tmr_vote_reg_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         en_i,
  input logic [W-1:0] din_a_i,
  input logic [W-1:0] din_b_i,
  input logic [W-1:0] din_c_i,
  input logic [W-1:0] dout_a_o,
  input logic [W-1:0] dout_b_o,
  input logic [W-1:0] dout_c_o,
  input logic [W-1:0] mism_o,
  input logic [2:0]   err_o
);
  p_reset_clears_r1: assert property (@(posedge clk_i)
    rst_i |=> (dout_a_o == '0 && mism_o == '0 && err_o == 3'b000));

  p_stall_holds_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> ($stable(dout_a_o) && $stable(mism_o) && $stable(err_o)));

  p_clean_capture_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !rst_i && din_a_i == din_b_i && din_b_i == din_c_i)
      |=> (dout_a_o == $past(din_a_i) && err_o == 3'b000));

  p_single_masked_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !rst_i && din_b_i == din_c_i) |=> (dout_b_o == $past(din_b_i)));

  p_flags_consistent_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    ((|mism_o) == (|err_o)));

  p_outputs_agree_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (dout_a_o == dout_b_o && dout_b_o == dout_c_o));
endmodule

bind tmr_vote_reg tmr_vote_reg_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
  .din_a_i(din_a_i), .din_b_i(din_b_i), .din_c_i(din_c_i),
  .dout_a_o(dout_a_o), .dout_b_o(dout_b_o), .dout_c_o(dout_c_o),
  .mism_o(mism_o), .err_o(err_o)
);

// File: tb/tb_tmr_vote_reg.sv
`timescale 1ns/1ps
module tb_tmr_vote_reg;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [W-1:0] da = '0, db = '0, dc = '0;
  logic [W-1:0] oa, ob, oc, mm, va, vb, vc, vmm;
  logic [2:0]   er, ver;

  int n_chk = 0;
  int n_err = 0;

  logic [W-1:0] ma = '0, mb = '0, mc = '0;

  always #4 clk = ~clk;

  tmr_vote_reg #(.W(W), .UPSTREAM_TMR(1'b1)) dut (
    .clk_i(clk), .rst_i(rst), .en_i(en), .din_a_i(da), .din_b_i(db), .din_c_i(dc),
    .dout_a_o(oa), .dout_b_o(ob), .dout_c_o(oc), .mism_o(mm), .err_o(er));

  tmr_vote_reg #(.W(W), .UPSTREAM_TMR(1'b0)) dut_v (
    .clk_i(clk), .rst_i(rst), .en_i(en), .din_a_i(da), .din_b_i(db), .din_c_i(dc),
    .dout_a_o(va), .dout_b_o(vb), .dout_c_o(vc), .mism_o(vmm), .err_o(ver));

  function automatic logic [W-1:0] bm_major(input logic [W-1:0] a, b, c);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      int ones;
      ones = int'(a[i]) + int'(b[i]) + int'(c[i]);
      r[i] = (ones >= 2);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] bm_split(input logic [W-1:0] a, b, c);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = !((a[i] == b[i]) && (a[i] == c[i]));
    return r;
  endfunction

  function automatic logic [2:0] bm_dissent(input logic [W-1:0] a, b, c);
    logic [W-1:0] m;
    m = bm_major(a, b, c);
    return {c != m, b != m, a != m};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [W-1:0] m;
    m = bm_major(ma, mb, mc);
    chk({tag, " dout_a"}, 64'(oa), 64'(m));
    chk({tag, " dout_b"}, 64'(ob), 64'(m));
    chk({tag, " dout_c"}, 64'(oc), 64'(m));
    chk({tag, " R5 mism"}, 64'(mm), 64'(bm_split(ma, mb, mc)));
    chk({tag, " err"}, 64'(er), 64'(bm_dissent(ma, mb, mc)));
    chk("R9 outputs equal", 64'(oa == ob && ob == oc), 64'd1);
  endtask

  // drive at negedge, let one edge pass, update model, sample at the next negedge
  task automatic step(input logic r, input logic e,
                      input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    @(negedge clk);
    rst = r; en = e; da = a; db = b; dc = c;
    @(posedge clk);
    if (r) begin
      ma = '0; mb = '0; mc = '0;
    end else if (e) begin
      ma = a; mb = b; mc = c;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [W-1:0] v, msk, prev;
    void'($urandom(32'h5eed_7a11));

    // R1: reset, including with enable high and data present
    step(1'b1, 1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    check_all("R1 reset");
    chk("R1 reset dout", 64'(oa), 64'd0);

    // R3: clean capture
    step(1'b0, 1'b1, 32'hA5A5_0F0F, 32'hA5A5_0F0F, 32'hA5A5_0F0F);
    check_all("R3 clean");
    chk("R3 clean value", 64'(oa), 64'hA5A5_0F0F);

    // R2: stall with different inputs holds the stored word
    step(1'b0, 1'b0, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333);
    chk("R2 hold", 64'(oa), 64'hA5A5_0F0F);
    chk("R2 hold err", 64'(er), 64'd0);

    // R4: single fault on lane b
    step(1'b0, 1'b1, 32'h0000_00F0, 32'h0000_00F1, 32'h0000_00F0);
    check_all("R4 single");
    chk("R4 value", 64'(oa), 64'h0000_00F0);
    chk("R4 err lane b", 64'(er), 64'b010);
    chk("R8 voted-input err", 64'(ver), 64'd0);
    chk("R8 voted-input mism", 64'(vmm), 64'd0);
    chk("R8 voted-input out", 64'(vc), 64'h0000_00F0);

    // R6: double fault in bit 4 on lanes a and c
    step(1'b0, 1'b1, 32'h0000_0010, 32'h0000_0000, 32'h0000_0010);
    chk("R6 wrong value passes", 64'(oa), 64'h0000_0010);
    chk("R6 mism bit 4", 64'(mm), 64'h0000_0010);
    chk("R6 err lane b", 64'(er), 64'b010);

    // R7: next clean word clears everything with no extra cycle
    step(1'b0, 1'b1, 32'h7777_0001, 32'h7777_0001, 32'h7777_0001);
    chk("R7 recovered value", 64'(oa), 64'h7777_0001);
    chk("R7 flags clear", 64'({mm, er}), 64'd0);

    // R1: reset while holding a faulted word
    step(1'b0, 1'b1, 32'h0, 32'hFFFF_FFFF, 32'h0);
    step(1'b1, 1'b0, 32'h0, 32'h0, 32'h0);
    chk("R1 reset clears fault", 64'({oa, mm, er}), 64'd0);

    // random mix: clean, single-lane and double-lane faults, stalls
    for (int n = 0; n < 400; n++) begin
      int mode, lane;
      logic [W-1:0] a, b, c;
      logic e;
      v    = $urandom;
      msk  = $urandom | 32'h1;
      mode = $urandom % 4;
      lane = $urandom % 3;
      e    = ($urandom % 5) != 0;
      a = v; b = v; c = v;
      if (mode == 2) begin
        if (lane == 0) a = v ^ msk; else if (lane == 1) b = v ^ msk; else c = v ^ msk;
      end else if (mode == 3) begin
        if (lane != 0) a = v ^ msk;
        if (lane != 1) b = v ^ msk;
        if (lane != 2) c = v ^ msk;
      end
      prev = oa;
      step(1'b0, e, a, b, c);
      if (!e)             check_all("R2 random hold");
      else if (mode == 2) check_all("R4 random single");
      else if (mode == 3) check_all("R6 random double");
      else                check_all("R3 random clean");
      if (!e) chk("R2 random stable", 64'(oa), 64'(prev));
      if (e && mode == 2) begin
        chk("R8 random single out", 64'(va), 64'(v));
        chk("R8 random single flags", 64'({vmm, ver}), 64'd0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule